// File: doc/BRIEF.md
# UART Receive Character Buffer with Automatic Flow Control

This block is the receive-side storage stage of a UART. A deserializer hands it complete characters, each an 8-bit value with three per-character error flags. The block stores them in a 32-entry buffer that preserves arrival order, and the host register interface reads them back. When buffering is switched off, the same storage behaves as a single holding register.

The block raises a receive interrupt from the fill level, compared against a trigger that the host selects. It flags an overrun when a character arrives with no room for it. It also drives an active-low request-to-send line with hysteresis on its own, so that a remote transmitter is paused before the buffer fills and released once the host has drained it.

The flow-control state machine has three states. FLOW_IDLE is used while automatic control is off, and the line then follows the manual control bit. FLOW_GO holds the line low, so the sender may transmit. FLOW_HOLD holds the line high, so the sender is paused. The transitions are:
- idle_to_go: automatic control turns on at or below the upper threshold.
- idle_to_hold: automatic control turns on above the upper threshold.
- go_to_hold: the fill rises above the upper threshold.
- hold_to_go: the fill drops below the lower threshold.
- any_to_idle: automatic control turns off.

Top module: `rx_fifo_rts`

## Requirements
- R1: After reset, `fill_level` is 0, and `data_ready`, `overrun` and `rx_int` are 0. With `rts_ctrl` at 0, `rts_n` is 1.
- R2: In buffered mode (`fifo_en`=1), up to 32 characters are kept. They are read out in arrival order. Each one appears on `rd_data` together with its own flags on `rd_err`, where bit 2 is break, bit 1 is framing and bit 0 is parity. The oldest entry is shown while `data_ready` is 1, and a one-cycle `rd_req` removes it.
- R3: `data_ready` goes to 1 on the clock edge that stores a character. It returns to 0 on the edge where a read leaves the storage empty.
- R4: A character that arrives while the storage is full, with no read in the same cycle, is dropped and leaves the stored contents as they were. The drop sets `overrun` on that edge. `overrun` stays at 1 until a `stat_rd` pulse clears it on the following edge.
- R5: A write and a read in the same cycle while the storage is full are both carried out. The level stays at full and `overrun` is not set.
- R6: In buffered mode, with `rx_int_en`=1, `rx_int` is 1 exactly while the fill level is at or above the trigger. `trig_sel` selects the trigger: 00 gives 8, 01 gives 16, 10 gives 24 and 11 gives 28. With `rx_int_en`=0, `rx_int` stays 0.
- R7: With `fifo_en`=0, the block holds one character. A second arrival before a read counts as an overrun under the rule in R4. `rx_int` equals `rx_int_en` while that character is held.
- R8: On the edge after `fifo_en` falls from 1 to 0, `fill_level` is 0 and every stored entry is discarded.
- R9: When `auto_rts_en`, `rts_ctrl` and `fifo_en` are all 1, `rts_n` goes high one edge after the level exceeds trigger+8, with that threshold limited to 32. It goes low one edge after the level drops below trigger−8, with that threshold limited to 0.
- R10: While automatic control has been off for at least one cycle, `rts_n` is the inverse of `rts_ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects buffered mode, 0 selects single holding register |
| rx_int_en | input | 1 | Receive interrupt enable |
| auto_rts_en | input | 1 | Automatic flow-control enable |
| rts_ctrl | input | 1 | Manual request-to-send bit, also gates automatic control |
| trig_sel | input | 2 | Interrupt trigger select (8/16/24/28) |
| wr_valid | input | 1 | Character strobe from the deserializer |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Per-character flags: break, framing, parity |
| rd_req | input | 1 | Host reads the oldest character |
| stat_rd | input | 1 | Host reads status; clears overrun |
| rd_data | output | 8 | Oldest stored character |
| rd_err | output | 3 | Flags of the oldest stored character |
| fill_level | output | 6 | Number of stored characters |
| data_ready | output | 1 | At least one character is stored |
| overrun | output | 1 | Sticky dropped-character flag |
| rx_int | output | 1 | Receive interrupt |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
A host read and a deserializer write can land in the same cycle while the storage is full. This is the case where a wrong room calculation either drops the character or overfills the storage. The bench first fills all 32 entries and confirms that a lone extra write is dropped. It then raises `rd_req` and `wr_valid` together. The expected result is that the level stays at 32 with no new overrun. A full drain must then return the 31 remaining entries followed by the new character, in order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CHAR_W = 8;
    localparam int ERR_W  = 3;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [CHAR_W-1:0] data;
    } rx_ent_t;

    typedef enum logic [1:0] {
        FLOW_IDLE = 2'd0,
        FLOW_GO   = 2'd1,
        FLOW_HOLD = 2'd2
    } flow_st_t;

    function automatic int trig_of(input logic [1:0] sel);
        unique case (sel)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 24;
            default: return 28;
        endcase
    endfunction

    function automatic int upper_of(input int trig, input int hyst, input int depth);
        return (trig + hyst > depth) ? depth : trig + hyst;
    endfunction

    function automatic int lower_of(input int trig, input int hyst);
        return (trig > hyst) ? trig - hyst : 0;
    endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] limit,
    input  logic          push,
    input  rx_ent_t       push_ent,
    input  logic          pop,
    output rx_ent_t       head,
    output logic [CW-1:0] level,
    output logic          dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_ent_t       mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_pop, do_push, room;

    assign do_pop  = pop && (level != '0);
    assign room    = (level < limit) || do_pop;
    assign do_push = push && room;
    assign dropped = push && !room && !flush;
    assign head    = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!flush && do_push) begin
            mem[wp] <= push_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/rxf_flow.sv
module rxf_flow
    import rxf_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_on,
    input  logic          rts_ctrl,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] upper,
    input  logic [CW-1:0] lower,
    output logic          rts_n
);
    flow_st_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FLOW_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            FLOW_IDLE: begin
                if (auto_on) nxt = (level > upper) ? FLOW_HOLD : FLOW_GO;
            end
            FLOW_GO: begin
                if (!auto_on)          nxt = FLOW_IDLE;
                else if (level > upper) nxt = FLOW_HOLD;
            end
            FLOW_HOLD: begin
                if (!auto_on)          nxt = FLOW_IDLE;
                else if (level < lower) nxt = FLOW_GO;
            end
            default: nxt = FLOW_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            FLOW_GO:   rts_n = 1'b0;
            FLOW_HOLD: rts_n = 1'b1;
            default:   rts_n = !rts_ctrl;
        endcase
    end
endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          rx_int_en,
    input  logic          dropped,
    input  logic          stat_rd,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trig,
    output logic          overrun,
    output logic          data_ready,
    output logic          rx_int
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (dropped) overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;
    end

    assign data_ready = (level != '0);
    assign rx_int     = rx_int_en && (fifo_en ? (level >= trig) : data_ready);
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
    import rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int HYST  = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_int_en,
    input  logic              auto_rts_en,
    input  logic              rts_ctrl,
    input  logic [1:0]        trig_sel,
    input  logic              wr_valid,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_req,
    input  logic              stat_rd,
    output logic [CHAR_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    output logic [CW-1:0]     fill_level,
    output logic              data_ready,
    output logic              overrun,
    output logic              rx_int,
    output logic              rts_n
);
    logic          fifo_en_q, flush, dropped, auto_on;
    logic [CW-1:0] limit, trig, upper, lower;
    rx_ent_t       head, in_ent;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_en_q <= 1'b0;
        else        fifo_en_q <= fifo_en;
    end

    assign flush   = fifo_en_q && !fifo_en;
    assign limit   = fifo_en ? CW'(DEPTH) : CW'(1);
    assign trig    = CW'(trig_of(trig_sel));
    assign upper   = CW'(upper_of(trig_of(trig_sel), HYST, DEPTH));
    assign lower   = CW'(lower_of(trig_of(trig_sel), HYST));
    assign auto_on = auto_rts_en && rts_ctrl && fifo_en;
    assign in_ent  = '{err: wr_err, data: wr_data};
    assign rd_data = head.data;
    assign rd_err  = head.err;

    rxf_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .limit(limit),
        .push(wr_valid), .push_ent(in_ent), .pop(rd_req),
        .head(head), .level(fill_level), .dropped(dropped)
    );

    rxf_status #(.CW(CW)) u_status (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_int_en(rx_int_en),
        .dropped(dropped), .stat_rd(stat_rd), .level(fill_level), .trig(trig),
        .overrun(overrun), .data_ready(data_ready), .rx_int(rx_int)
    );

    rxf_flow #(.CW(CW)) u_flow (
        .clk(clk), .rst_n(rst_n), .auto_on(auto_on), .rts_ctrl(rts_ctrl),
        .level(fill_level), .upper(upper), .lower(lower), .rts_n(rts_n)
    );
endmodule

// File: rtl/rx_fifo_rts_chk.sv
module rx_fifo_rts_chk
    import rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int HYST  = 8,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          rx_int_en,
    input logic          auto_rts_en,
    input logic          rts_ctrl,
    input logic [1:0]    trig_sel,
    input logic          wr_valid,
    input logic          rd_req,
    input logic [CW-1:0] fill_level,
    input logic          data_ready,
    input logic          overrun,
    input logic          rx_int,
    input logic          rts_n
);
    int  lvl, t;
    logic aon;
    assign lvl = int'(fill_level);
    assign t   = trig_of(trig_sel);
    assign aon = auto_rts_en && rts_ctrl && fifo_en;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= DEPTH);

    // R3
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(wr_valid));

    // R4
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && wr_valid && lvl == DEPTH && !rd_req) |=> overrun);

    // R5
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && wr_valid && rd_req && lvl == DEPTH) |=> (fill_level == $past(fill_level) || !fifo_en));

    // R6
    int_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_int_en && lvl >= t) |-> rx_int);

    // R6
    int_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && lvl < t) |-> !rx_int);

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_en) |=> (fill_level == '0));

    // R9
    rts_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aon && lvl > upper_of(t, HYST, DEPTH)) |=> (rts_n || !(auto_rts_en && rts_ctrl && fifo_en)));

    // R9
    rts_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aon && lvl < lower_of(t, HYST)) |=> (!rts_n || !(auto_rts_en && rts_ctrl && fifo_en)));

    // R10
    rts_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aon && $past(!aon)) |-> (rts_n == !rts_ctrl));
endmodule

bind rx_fifo_rts rx_fifo_rts_chk #(.DEPTH(DEPTH), .HYST(HYST), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_int_en(rx_int_en),
    .auto_rts_en(auto_rts_en), .rts_ctrl(rts_ctrl), .trig_sel(trig_sel),
    .wr_valid(wr_valid), .rd_req(rd_req), .fill_level(fill_level),
    .data_ready(data_ready), .overrun(overrun), .rx_int(rx_int), .rts_n(rts_n)
);

// File: tb/sim_rx_fifo_rts.sv
module sim_rx_fifo_rts;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, rx_int_en = 1'b0, auto_rts_en = 1'b0, rts_ctrl = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       wr_valid = 1'b0, rd_req = 1'b0, stat_rd = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_err = '0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [5:0] fill_level;
    logic       data_ready, overrun, rx_int, rts_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rx_fifo_rts u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_int_en(rx_int_en),
        .auto_rts_en(auto_rts_en), .rts_ctrl(rts_ctrl), .trig_sel(trig_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_err(wr_err),
        .rd_req(rd_req), .stat_rd(stat_rd), .rd_data(rd_data), .rd_err(rd_err),
        .fill_level(fill_level), .data_ready(data_ready), .overrun(overrun),
        .rx_int(rx_int), .rts_n(rts_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        wr_valid = 1'b1; wr_data = d; wr_err = e;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic pop();
        rd_req = 1'b1;
        step();
        rd_req = 1'b0;
    endtask

    task automatic flush_all();
        fifo_en = 1'b0; step(); step();
        fifo_en = 1'b1; step();
    endtask

    task automatic t_reset();
        chk("R1", "level", fill_level, 0);
        chk("R1", "ready", data_ready, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "int", rx_int, 0);
        chk("R1", "rts_n", rts_n, 1);
    endtask

    task automatic t_order();
        fifo_en = 1'b1; step();
        push(8'h11, 3'b001);
        chk("R3", "ready after first store", data_ready, 1);
        push(8'h22, 3'b010);
        push(8'h33, 3'b100);
        push(8'h44, 3'b000);
        push(8'h55, 3'b111);
        for (int i = 0; i < 5; i++) begin
            chk("R2", "head data", rd_data, (i + 1) * 8'h11);
            chk("R2", "head flags", rd_err, (i == 0) ? 1 : (i == 1) ? 2 : (i == 2) ? 4 : (i == 3) ? 0 : 7);
            if (i == 4) chk("R3", "ready before last read", data_ready, 1);
            pop();
        end
        chk("R3", "ready after drain", data_ready, 0);
    endtask

    task automatic t_trigger();
        trig_sel = 2'b01; rx_int_en = 1'b1;
        for (int i = 0; i < 15; i++) push(8'(i), 3'b000);
        chk("R6", "int at 15 of 16", rx_int, 0);
        push(8'd15, 3'b000);
        chk("R6", "int at 16 of 16", rx_int, 1);
        trig_sel = 2'b11; #1;
        chk("R6", "int at 16 of 28", rx_int, 0);
        trig_sel = 2'b00; #1;
        chk("R6", "int at 16 of 8", rx_int, 1);
        trig_sel = 2'b01;
        pop();
        chk("R6", "int at 15 after read", rx_int, 0);
        push(8'd16, 3'b000);
        rx_int_en = 1'b0; #1;
        chk("R6", "int masked", rx_int, 0);
        fifo_en = 1'b0; step();
        chk("R8", "level after flush", fill_level, 0);
        fifo_en = 1'b1; step();
    endtask

    task automatic t_rts();
        trig_sel = 2'b01; auto_rts_en = 1'b1; rts_ctrl = 1'b1;
        step();
        chk("R9", "rts_n when enabled empty", rts_n, 0);
        for (int i = 0; i < 24; i++) push(8'(i), 3'b000);
        step();
        chk("R9", "rts_n at 24", rts_n, 0);
        push(8'd24, 3'b000);
        step();
        chk("R9", "rts_n at 25", rts_n, 1);
        for (int i = 0; i < 17; i++) pop();
        step();
        chk("R9", "rts_n at 8", rts_n, 1);
        pop();
        step();
        chk("R9", "rts_n at 7", rts_n, 0);
        auto_rts_en = 1'b0; step(); step();
        chk("R10", "manual rts_ctrl=1", rts_n, 0);
        rts_ctrl = 1'b0; #1;
        chk("R10", "manual rts_ctrl=0", rts_n, 1);
        flush_all();
    endtask

    task automatic t_full();
        for (int i = 0; i < 32; i++) push(8'(i + 8'h40), 3'(i));
        chk("R2", "level full", fill_level, 32);
        chk("R4", "no overrun yet", overrun, 0);
        push(8'hAA, 3'b101);
        chk("R4", "level after drop", fill_level, 32);
        chk("R4", "overrun set", overrun, 1);
        step();
        chk("R4", "overrun sticky", overrun, 1);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        chk("R4", "overrun cleared", overrun, 0);
        wr_valid = 1'b1; wr_data = 8'hBB; wr_err = 3'b110; rd_req = 1'b1;
        step();
        wr_valid = 1'b0; rd_req = 1'b0;
        chk("R5", "level after swap", fill_level, 32);
        chk("R5", "no overrun on swap", overrun, 0);
        for (int i = 1; i < 32; i++) begin
            chk("R4", "stored data kept", rd_data, i + 8'h40);
            chk("R4", "stored flags kept", rd_err, i % 8);
            pop();
        end
        chk("R5", "swapped char last", rd_data, 8'hBB);
        chk("R5", "swapped flags last", rd_err, 6);
        pop();
        chk("R3", "empty after full drain", data_ready, 0);
    endtask

    task automatic t_hold();
        fifo_en = 1'b0; rx_int_en = 1'b1; step();
        push(8'h5A, 3'b010);
        chk("R7", "ready single", data_ready, 1);
        chk("R7", "int single", rx_int, 1);
        push(8'hA5, 3'b000);
        chk("R7", "overrun single", overrun, 1);
        chk("R7", "held char kept", rd_data, 8'h5A);
        chk("R7", "level single", fill_level, 1);
        pop();
        chk("R7", "ready after read", data_ready, 0);
        chk("R7", "int after read", rx_int, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_order();
        t_trigger();
        t_rts();
        t_full();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule